// File: doc/BRIEF.md
# Multi-channel edge wake-up unit

This block watches a set of asynchronous external input lines, one per channel. Each line first passes through a multi-flop synchroniser. The synchronised value is then compared with its value one clock earlier. When a channel shows the edge its polarity bit asks for (rising or falling), a sticky pending flag for that channel is set. Software removes a pending flag by pulsing the matching bit of a write-one-to-clear mask. When an edge and a clear reach the same flag in the same cycle, the edge wins.

The pending flags are gated by the per-channel enable and then grouped onto a small number of interrupt lines. A per-channel routing field picks the interrupt line each channel feeds. The same gated flags also drive a single wake request, which a clock and power-mode controller can use to leave a halt, idle or power-save state. The wake request does not depend on the routing. A channel that is disabled still records its edges in its pending flag, but it raises no interrupt and no wake request until it is enabled.

Top module: `edge_wake_unit`

## Requirements
- R1: An input change driven before clock edge k shows on `pend_o` after edge k+2 and not earlier. This is a two-flop synchroniser followed by a one-cycle edge compare and the pending register.
- R2: When `cfg_fall[c]` is 0, a 0-to-1 transition of `chan_in[c]` sets `pend_o[c]`. When it is 1, a 1-to-0 transition sets it. The opposite transition leaves the flag unchanged.
- R3: A pending flag stays set until a cycle in which `clr_mask[c]` is 1. Clear-mask bits that are 0 leave their flags untouched.
- R4: When an edge sets a flag in the same cycle that its clear bit is 1, the flag ends up set.
- R5: `cfg_route[2c+1:2c]` holds the index of the interrupt line that channel c feeds. `irq_o[k]` is high exactly when some channel routed to k is both pending and enabled.
- R6: A channel with `cfg_enable[c]` at 0 still sets `pend_o[c]` on its edge, but it drives neither `irq_o` nor `wake_o`.
- R7: `wake_o` is high exactly when at least one enabled channel is pending, whatever its routing.
- R8: Changing `cfg_fall[c]` while `chan_in[c]` is steady never sets `pend_o[c]`.
- R9: While `rst_n` is low and directly after reset, `pend_o`, `irq_o` and `wake_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_in | input | 16 | Asynchronous channel inputs |
| cfg_enable | input | 16 | Per-channel enable |
| cfg_fall | input | 16 | Per-channel polarity: 1 selects falling edge, 0 selects rising edge |
| cfg_route | input | 32 | Two bits per channel selecting the interrupt line |
| clr_mask | input | 16 | Write-one-to-clear pulse for the pending flags |
| pend_o | output | 16 | Pending flags |
| irq_o | output | 4 | Grouped interrupt lines |
| wake_o | output | 1 | Wake request to the power-mode controller |

## Verification
The synchroniser flops reset to zero. For that reason the assertions that tie a rising pending flag back to an input transition take for granted that every channel input is held low while reset is applied. The bench keeps all inputs and the clear mask low until reset is released. It then moves each input only at falling clock edges and holds it for several cycles, so that every edge travels through the synchroniser before the next change arrives. Configuration and clear pulses are likewise driven at falling edges, which means each one is sampled cleanly by a single rising edge.

// File: rtl/ewu_pkg.sv
package ewu_pkg;
   // Width of a routing field able to name n_out interrupt lines (at least one bit)
   function automatic int sel_width(input int n_out);
      return (n_out > 1) ? $clog2(n_out) : 1;
   endfunction
endpackage

// File: rtl/ewu_sync.sv
module ewu_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ewu_edge.sv
module ewu_edge #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level_i,
   input  logic [WIDTH-1:0] fall_sel,
   output logic [WIDTH-1:0] hit_o
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] rise_w, fall_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level_i;
   end

   // Polarity chooses between two real transitions, so flipping it alone cannot create one
   assign rise_w = level_i & ~prev_q;
   assign fall_w = ~level_i & prev_q;
   assign hit_o  = (fall_sel & fall_w) | (~fall_sel & rise_w);
endmodule

// File: rtl/ewu_pending.sv
module ewu_pending #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] pend_o
);
   logic [WIDTH-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_i) | set_i;
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/ewu_route.sv
module ewu_route #(
   parameter int N_CH  = 16,
   parameter int N_OUT = 4,
   parameter int SEL_W = 2
) (
   input  logic [N_CH-1:0]       pend_i,
   input  logic [N_CH-1:0]       en_i,
   input  logic [N_CH*SEL_W-1:0] route_i,
   output logic [N_OUT-1:0]      irq_o,
   output logic                  wake_o
);
   logic [N_CH-1:0] live_w;
   assign live_w = pend_i & en_i;

   if (N_OUT == 1) begin : g_single
      assign irq_o[0] = |live_w;
   end else begin : g_multi
      for (genvar k = 0; k < N_OUT; k++) begin : g_line
         localparam logic [SEL_W-1:0] KSEL = SEL_W'(k);
         logic [N_CH-1:0] member_w;
         for (genvar c = 0; c < N_CH; c++) begin : g_ch
            assign member_w[c] = (route_i[c*SEL_W +: SEL_W] == KSEL);
         end
         assign irq_o[k] = |(live_w & member_w);
      end
   end

   assign wake_o = |live_w;
endmodule

// File: rtl/edge_wake_unit.sv
module edge_wake_unit #(
   parameter int N_CH        = 16,
   parameter int N_OUT       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = ewu_pkg::sel_width(N_OUT)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_CH-1:0]       chan_in,
   input  logic [N_CH-1:0]       cfg_enable,
   input  logic [N_CH-1:0]       cfg_fall,
   input  logic [N_CH*SEL_W-1:0] cfg_route,
   input  logic [N_CH-1:0]       clr_mask,
   output logic [N_CH-1:0]       pend_o,
   output logic [N_OUT-1:0]      irq_o,
   output logic                  wake_o
);
   if (N_CH < 1) begin : g_bad_ch
      $error("edge_wake_unit: N_CH must be at least 1");
   end
   if (N_OUT < 1 || N_OUT > (1 << SEL_W)) begin : g_bad_out
      $error("edge_wake_unit: N_OUT does not fit the routing field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("edge_wake_unit: SYNC_STAGES must be at least 2");
   end

   logic [N_CH-1:0] level_w;
   logic [N_CH-1:0] hit_w;

   ewu_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(chan_in), .dout(level_w)
   );

   ewu_edge #(.WIDTH(N_CH)) u_edge (
      .clk(clk), .rst_n(rst_n), .level_i(level_w), .fall_sel(cfg_fall), .hit_o(hit_w)
   );

   ewu_pending #(.WIDTH(N_CH)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_i(hit_w), .clr_i(clr_mask), .pend_o(pend_o)
   );

   ewu_route #(.N_CH(N_CH), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_route (
      .pend_i(pend_o), .en_i(cfg_enable), .route_i(cfg_route),
      .irq_o(irq_o), .wake_o(wake_o)
   );
endmodule

// File: rtl/ewu_checks.sv
module ewu_checks #(
   parameter int N_CH        = 16,
   parameter int N_OUT       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [N_CH-1:0]       chan_in,
   input logic [N_CH-1:0]       cfg_enable,
   input logic [N_CH-1:0]       cfg_fall,
   input logic [N_CH*SEL_W-1:0] cfg_route,
   input logic [N_CH-1:0]       clr_mask,
   input logic [N_CH-1:0]       pend_o,
   input logic [N_OUT-1:0]      irq_o,
   input logic                  wake_o
);
   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      // R1: a new flag needs an input transition that has crossed the synchroniser
      assert_edge_origin_R1: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_o[i]) |-> ($past(chan_in[i], SYNC_STAGES+1) != $past(chan_in[i], SYNC_STAGES+2)));

      // R2: that transition ends on the level the polarity asks for
      assert_edge_polarity_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_o[i]) |-> ($past(chan_in[i], SYNC_STAGES+1) == !$past(cfg_fall[i], 1)));

      // R3: sticky without a clear
      assert_pend_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_o[i] && !clr_mask[i]) |=> pend_o[i]);

      // R3: a clear with no edge in flight drops the flag
      assert_pend_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_o[i] && clr_mask[i] &&
          ($past(chan_in[i], SYNC_STAGES) == $past(chan_in[i], SYNC_STAGES+1))) |=> !pend_o[i]);
   end

   // R7: any raised interrupt line implies a wake request
   assert_irq_implies_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_o) |-> wake_o);

   // R6: nothing enabled means no wake and no interrupt
   assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_enable == '0) |-> (!wake_o && irq_o == '0));
endmodule

bind edge_wake_unit ewu_checks #(
   .N_CH(N_CH), .N_OUT(N_OUT), .SYNC_STAGES(SYNC_STAGES), .SEL_W(SEL_W)
) u_checks (
   .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .cfg_enable(cfg_enable),
   .cfg_fall(cfg_fall), .cfg_route(cfg_route), .clr_mask(clr_mask),
   .pend_o(pend_o), .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/tb_edge_wake_unit.sv
module tb_edge_wake_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 16;
   localparam int NO = 4;
   localparam int LAT = 3; // 2 sync flops + pending register

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] chan_in = '0;
   logic [NC-1:0] cfg_enable = '0;
   logic [NC-1:0] cfg_fall = '0;
   logic [2*NC-1:0] cfg_route = '0;
   logic [NC-1:0] clr_mask = '0;
   logic [NC-1:0] pend_o;
   logic [NO-1:0] irq_o;
   logic          wake_o;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   edge_wake_unit dut (
      .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .cfg_enable(cfg_enable),
      .cfg_fall(cfg_fall), .cfg_route(cfg_route), .clr_mask(clr_mask),
      .pend_o(pend_o), .irq_o(irq_o), .wake_o(wake_o)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic clear_all();
      clr_mask = '1;
      tick(1);
      clr_mask = '0;
   endtask

   initial begin
      tick(3);
      check("R9 pend in reset", 32'(pend_o), 0);
      check("R9 irq in reset", 32'(irq_o), 0);
      check("R9 wake in reset", 32'(wake_o), 0);
      rst_n = 1'b1;
      tick(4);
      check("R9 pend after reset", 32'(pend_o), 0);
      check("R9 wake after reset", 32'(wake_o), 0);

      // Sweep: every channel, both polarities, every route, enabled and disabled
      for (int c = 0; c < NC; c++) begin
         for (int p = 0; p < 2; p++) begin
            for (int r = 0; r < NO; r++) begin
               for (int e = 0; e < 2; e++) begin
                  logic [NC-1:0] bit_c;
                  bit_c = NC'(1) << c;
                  for (int j = 0; j < NC; j++)
                     cfg_route[2*j +: 2] = (j == c) ? 2'(r) : 2'((r + 1) % NO);
                  cfg_fall = p ? bit_c : '0;
                  cfg_enable = e ? bit_c : '0;
                  chan_in[c] = p[0];          // idle level
                  tick(5);
                  clear_all();
                  check("R3 cleared before case", 32'(pend_o), 0);
                  chan_in[c] = ~p[0];         // active edge
                  tick(LAT - 1);
                  check("R1 not yet pending", 32'(pend_o), 0);
                  tick(1);
                  check("R1 R2 pending on active edge", 32'(pend_o), 32'(bit_c));
                  check("R5 R6 irq routing", 32'(irq_o), e ? (32'(1) << r) : 0);
                  check("R7 R6 wake", 32'(wake_o), 32'(e));
                  clr_mask = ~bit_c;
                  tick(1);
                  clr_mask = '0;
                  check("R3 unmasked bits keep flag", 32'(pend_o), 32'(bit_c));
                  clr_mask = bit_c;
                  tick(1);
                  clr_mask = '0;
                  check("R3 write-one clears", 32'(pend_o), 0);
                  chan_in[c] = p[0];          // inactive edge
                  tick(LAT + 1);
                  check("R2 opposite edge ignored", 32'(pend_o), 0);
               end
            end
         end
      end

      // R4: edge and clear in the same cycle
      cfg_fall = '0; cfg_enable = '1; chan_in = '0;
      tick(5); clear_all();
      chan_in[5] = 1'b1;
      tick(LAT - 1);
      clr_mask = NC'(1) << 5;
      tick(1);
      clr_mask = '0;
      check("R4 set wins over clear", 32'(pend_o), 32'(1) << 5);

      // R8: polarity flip with steady inputs
      chan_in = '1;
      tick(5); clear_all();
      cfg_fall = '1;
      tick(LAT + 2);
      check("R8 flip to falling sets nothing", 32'(pend_o), 0);
      cfg_fall = '0;
      tick(LAT + 2);
      check("R8 flip to rising sets nothing", 32'(pend_o), 0);

      // R5 R7: all channels at once, routes c mod 4
      chan_in = '0;
      tick(5); clear_all();
      for (int j = 0; j < NC; j++) cfg_route[2*j +: 2] = 2'(j % NO);
      chan_in = '1;
      tick(LAT);
      check("R5 all channels pending", 32'(pend_o), 32'hFFFF);
      check("R5 all lines raised", 32'(irq_o), 32'hF);
      clr_mask = 16'h7777;   // leave channels 3,7,11,15 -> line 3
      tick(1);
      clr_mask = '0;
      check("R5 only line 3 left", 32'(irq_o), 32'h8);
      cfg_enable = 16'h7FFF;
      tick(1);
      check("R5 line 3 from remaining enabled", 32'(irq_o), 32'h8);
      cfg_enable = 16'h0777;
      tick(1);
      check("R6 disabled pending hides irq", 32'(irq_o), 0);
      check("R7 no wake when pending are disabled", 32'(wake_o), 0);
      cfg_enable = 16'h0008;
      cfg_route[2*3 +: 2] = 2'd0;
      tick(1);
      check("R7 wake independent of route", 32'(wake_o), 1);
      check("R5 rerouted channel on line 0", 32'(irq_o), 32'h1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule